// File: doc/BRIEF.md
# Dual-Stream Serial Audio Port

This block is the serial front end of an audio effects engine. It serves two independent stereo streams, and each stream has one serial data input and one serial data output. All of them run on a single bit clock and share one frame sync pulse. A frame lasts 32 bit clocks and carries a single 16-bit stereo sample pair, left word first and then the right word, each sent MSB first in two's complement.

The block works in full duplex. While a frame is shifted in on each input, each output shifts out the pair that the processing core handed over during the previous frame. That pair is multiplied by a common 8-bit volume before it goes out. At the end of each frame the block registers both streams' received pairs onto a parallel bus and marks them with a single-cycle valid strobe. The core then has the whole next frame to produce its results, which it places on the parallel transmit inputs.

After reset the port stays silent until the first sync pulse. The outputs carry zeros through the first full frame that follows that pulse. A sync pulse that arrives out of step realigns the frame.

Top module: `dual_stream_audio_port`

## Requirements
- R1: Once synchronised, the port keeps 32-clock frames whether or not further sync pulses arrive, and raises `rx_valid_o` exactly once in each frame.
- R2: The input bit sampled on the clock edge where `sync_i` is high is bit 0 of the frame. Bits 0 to 15 form the left word and bits 16 to 31 form the right word, each MSB first.
- R3: The clock cycle after the edge that samples bit 31 of a frame, `rx_valid_o` is high for one cycle. At that point `rx_left_o` and `rx_right_o` hold that frame's words, and they keep those values until the next strobe.
- R4: The transmit words present at the edge that samples bit 31 are sent in the following frame, MSB first, left then right. Output bit k is on `sdout_o` during the cycle that ends with the edge sampling input bit k.
- R5: A volume of 255 transmits the sample unchanged.
- R6: A volume of 0 transmits zero.
- R7: Any other volume v transmits floor(s*v/256), where s is the signed sample.
- R8: A sync pulse at an unexpected bit position restarts the frame at bit 0. The cut-short frame gives no strobe, and the realigned frame is received correctly.
- R9: Before the first sync pulse, no strobe is raised and the outputs are zero. The outputs also carry zeros for the whole first frame after that pulse.
- R10: The two streams are independent. Each stream's received and transmitted words depend only on its own input pin and its own transmit words.
- R11: While reset is held, the outputs are zero and `rx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync; high on the edge that samples bit 0 |
| sdin_i | input | 2 | Serial inputs, bit s belongs to stream s |
| vol_i | input | 8 | Output volume, 0 = silent, 255 = unity |
| tx_left_i | input | 32 | Left transmit words, stream s at [16s +: 16] |
| tx_right_i | input | 32 | Right transmit words, stream s at [16s +: 16] |
| sdout_o | output | 2 | Serial outputs, bit s belongs to stream s |
| rx_left_o | output | 32 | Received left words, stream s at [16s +: 16] |
| rx_right_o | output | 32 | Received right words, stream s at [16s +: 16] |
| rx_valid_o | output | 1 | One-cycle strobe marking new received words |

## Verification
A table of frames drives each stream with distinct words. These include full-scale positive and negative values, sign-bit-only patterns and alternating bits, which expose swapped halves, a reversed bit order or crossed streams. Frames are sent with a sync pulse and without one in turn, which separates free-running framing from resynchronisation on every pulse. The volume is set to 255, 0, 1, 128, 200 and 254 against negative and odd samples, which shows whether the scaler takes the unity bypass, rounds toward minus infinity and sign-extends. Directed runs cover the idle period before sync, the silent first frame and a sync pulse placed mid-frame.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;
  localparam int DEF_STREAMS  = 2;
  localparam int DEF_SAMPLE_W = 16;
  localparam int DEF_VOL_W    = 8;

  function automatic int frame_len(input int sample_w);
    return 2 * sample_w;
  endfunction
endpackage

// File: rtl/audio_frame_timer.sv
module audio_frame_timer #(
  parameter int FRAME_BITS = 32,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic active_o,
  output logic locked_o,
  output logic frame_end_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] bit_q, bit_idx;
  logic          locked_q;

  always_comb begin
    if (sync_i)             bit_idx = '0;
    else if (bit_q == LAST) bit_idx = '0;
    else                    bit_idx = bit_q + 1'b1;
  end

  assign active_o    = locked_q | sync_i;
  assign locked_o    = locked_q;
  assign frame_end_o = active_o && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q    <= LAST;
      locked_q <= 1'b0;
    end else begin
      if (active_o) bit_q <= bit_idx;
      if (sync_i)   locked_q <= 1'b1;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (frame_end_o && !sync_i) |=> !frame_end_o); // R1
  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q); // R1
endmodule

// File: rtl/audio_vol_scaler.sv
module audio_vol_scaler #(
  parameter int SAMPLE_W = 16,
  parameter int VOL_W    = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [VOL_W-1:0]    vol_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int PW = SAMPLE_W + VOL_W + 1;

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = $signed(sample_i) * $signed({1'b0, vol_i});
    if (vol_i == '1) sample_o = sample_i;
    else             sample_o = SAMPLE_W'(prod >>> VOL_W);
  end
endmodule

// File: rtl/audio_rx_lane.sv
module audio_rx_lane #(
  parameter int SAMPLE_W = 16,
  localparam int WORD_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_i,
  input  logic                frame_end_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic [WORD_W-2:0] sr_q;
  logic [WORD_W-1:0] word;

  assign word = {sr_q, sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      if (shift_i) sr_q <= word[WORD_W-2:0];
      if (frame_end_i) begin
        left_o  <= word[WORD_W-1:SAMPLE_W];
        right_o <= word[SAMPLE_W-1:0];
      end
    end
  end

  AST_RX_RIGHT_LSB: assert property (@(posedge clk) disable iff (rst)
    frame_end_i |=> right_o[0] == $past(sd_i)); // R2
endmodule

// File: rtl/audio_tx_lane.sv
module audio_tx_lane #(
  parameter int SAMPLE_W = 16,
  parameter int VOL_W    = 8,
  localparam int WORD_W = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_i,
  input  logic                load_i,
  input  logic [VOL_W-1:0]    vol_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o
);
  logic [SAMPLE_W-1:0] left_s, right_s;
  logic [WORD_W-1:0]   word, sr_q;

  audio_vol_scaler #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_scale_l (
    .sample_i(left_i), .vol_i(vol_i), .sample_o(left_s));
  audio_vol_scaler #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_scale_r (
    .sample_i(right_i), .vol_i(vol_i), .sample_o(right_s));

  assign word = {left_s, right_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      sd_o <= 1'b0;
    end else if (load_i) begin
      sd_o <= word[WORD_W-1];
      sr_q <= {word[WORD_W-2:0], 1'b0};
    end else if (shift_i) begin
      sd_o <= sr_q[WORD_W-1];
      sr_q <= {sr_q[WORD_W-2:0], 1'b0};
    end
  end

  AST_MUTE_MSB: assert property (@(posedge clk) disable iff (rst)
    (load_i && vol_i == '0) |=> !sd_o); // R6
  AST_UNITY_MSB: assert property (@(posedge clk) disable iff (rst)
    (load_i && vol_i == '1) |=> sd_o == $past(left_i[SAMPLE_W-1])); // R5
endmodule

// File: rtl/dual_stream_audio_port.sv
module dual_stream_audio_port
  import audio_port_pkg::*;
#(
  parameter int STREAMS  = DEF_STREAMS,
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int VOL_W    = DEF_VOL_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_i,
  input  logic [STREAMS-1:0]           sdin_i,
  input  logic [VOL_W-1:0]             vol_i,
  input  logic [STREAMS*SAMPLE_W-1:0]  tx_left_i,
  input  logic [STREAMS*SAMPLE_W-1:0]  tx_right_i,
  output logic [STREAMS-1:0]           sdout_o,
  output logic [STREAMS*SAMPLE_W-1:0]  rx_left_o,
  output logic [STREAMS*SAMPLE_W-1:0]  rx_right_o,
  output logic                         rx_valid_o
);
  localparam int FRAME_BITS = frame_len(SAMPLE_W);

  logic active, locked, frame_end;

  audio_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst(rst), .sync_i(sync_i),
    .active_o(active), .locked_o(locked), .frame_end_o(frame_end));

  for (genvar s = 0; s < STREAMS; s++) begin : g_stream
    audio_rx_lane #(.SAMPLE_W(SAMPLE_W)) u_rx (
      .clk(clk), .rst(rst), .shift_i(active), .frame_end_i(frame_end),
      .sd_i(sdin_i[s]),
      .left_o(rx_left_o[s*SAMPLE_W +: SAMPLE_W]),
      .right_o(rx_right_o[s*SAMPLE_W +: SAMPLE_W]));

    audio_tx_lane #(.SAMPLE_W(SAMPLE_W), .VOL_W(VOL_W)) u_tx (
      .clk(clk), .rst(rst), .shift_i(active), .load_i(frame_end),
      .vol_i(vol_i),
      .left_i(tx_left_i[s*SAMPLE_W +: SAMPLE_W]),
      .right_i(tx_right_i[s*SAMPLE_W +: SAMPLE_W]),
      .sd_o(sdout_o[s]));
  end

  always_ff @(posedge clk) begin
    if (rst) rx_valid_o <= 1'b0;
    else     rx_valid_o <= frame_end;
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R3
  AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(rx_left_o) && $stable(rx_right_o))); // R3
  AST_SILENT_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (sdout_o == '0 && !rx_valid_o)); // R9
endmodule

// File: tb/dual_stream_audio_port_bench.sv
module dual_stream_audio_port_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic [1:0]  sdin = '0;
  logic [7:0]  vol = '0;
  logic [31:0] txl = '0, txr = '0;
  logic [1:0]  sdout;
  logic [31:0] rxl, rxr;
  logic        rxv;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_stream_audio_port u_dual_stream_audio_port (
    .clk(clk), .rst(rst), .sync_i(sync), .sdin_i(sdin), .vol_i(vol),
    .tx_left_i(txl), .tx_right_i(txr), .sdout_o(sdout),
    .rx_left_o(rxl), .rx_right_o(rxr), .rx_valid_o(rxv));

  // row: in L0, R0, L1, R1, tx L0, R0, L1, R1, volume
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV][9] = '{
    '{16'h1234, 16'hABCD, 16'h8000, 16'h7FFF, 16'h4000, 16'hC000, 16'h7FFF, 16'h8000, 16'h00FF},
    '{16'hFFFF, 16'h0001, 16'h5A5A, 16'hA5A5, 16'h1234, 16'hFEDC, 16'h0001, 16'hFFFF, 16'h0000},
    '{16'h0000, 16'h8000, 16'h0F0F, 16'hF0F0, 16'h7FFF, 16'h8000, 16'h0100, 16'hFF00, 16'h0080},
    '{16'h8001, 16'h7FFE, 16'h1111, 16'hEEEE, 16'hFFFF, 16'h0001, 16'h2468, 16'h9ABC, 16'h0001},
    '{16'hCAFE, 16'hBEEF, 16'h0000, 16'h0000, 16'h5555, 16'hAAAA, 16'h8000, 16'h7FFF, 16'h00C8},
    '{16'h0001, 16'hFFFE, 16'h3C3C, 16'hC3C3, 16'h0003, 16'hFFFD, 16'h1000, 16'hF000, 16'h00FE}
  };

  logic        got_valid;
  logic [15:0] got_rx [4];
  int          got_mid;
  logic [31:0] cap0, cap1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_scale(input logic [15:0] s, input logic [7:0] v);
    int p;
    if (v == 8'hFF) return s;
    p = int'($signed(s)) * int'(v);
    return 16'(p >>> 8);
  endfunction

  function automatic string vol_req(input logic [7:0] v);
    if (v == 8'hFF) return "R5";
    if (v == 8'h00) return "R6";
    return "R7";
  endfunction

  task automatic run_frame(input bit do_sync, input logic [15:0] d [9]);
    logic [31:0] w0, w1;
    w0 = {d[0], d[1]};
    w1 = {d[2], d[3]};
    got_mid = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (k == 0) begin
        got_valid = rxv;
        got_rx[0] = rxl[15:0];  got_rx[1] = rxr[15:0];
        got_rx[2] = rxl[31:16]; got_rx[3] = rxr[31:16];
        txl = {d[6], d[4]};
        txr = {d[7], d[5]};
        vol = d[8][7:0];
      end else if (rxv) got_mid++;
      cap0[31-k] = sdout[0];
      cap1[31-k] = sdout[1];
      sync    = do_sync && (k == 0);
      sdin[0] = w0[31-k];
      sdin[1] = w1[31-k];
    end
  endtask

  task automatic check_prev(input logic [15:0] p [9]);
    chk("R3 valid strobe", 32'(got_valid), 32'd1);
    chk("R1 single strobe", 32'(got_mid), 32'd0);
    chk("R2 rx left s0", 32'(got_rx[0]), 32'(p[0]));
    chk("R2 rx right s0", 32'(got_rx[1]), 32'(p[1]));
    chk("R10 rx left s1", 32'(got_rx[2]), 32'(p[2]));
    chk("R10 rx right s1", 32'(got_rx[3]), 32'(p[3]));
    chk({"R4 ", vol_req(p[8][7:0]), " tx s0"}, cap0,
        {exp_scale(p[4], p[8][7:0]), exp_scale(p[5], p[8][7:0])});
    chk({"R4 ", vol_req(p[8][7:0]), " R10 tx s1"}, cap1,
        {exp_scale(p[6], p[8][7:0]), exp_scale(p[7], p[8][7:0])});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [15:0] zero [9];
    logic [15:0] row [9];
    logic [15:0] junk [9];
    int bad;
    foreach (zero[j]) zero[j] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset sdout", 32'(sdout), 32'd0);
    chk("R11 reset valid", 32'(rxv), 32'd0);
    chk("R11 reset rx", rxl | rxr, 32'd0);
    rst = 1'b0;

    // R9: idle before any sync, with toggling inputs
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sdout != 0 || rxv) bad++;
      sdin = 2'(k);
      txl = 32'hFFFF_FFFF; txr = 32'h8000_8000; vol = 8'hFF;
    end
    chk("R9 idle before sync", 32'(bad), 32'd0);

    // table walk: sync on even rows, free-run on odd rows
    for (int i = 0; i <= NV; i++) begin
      for (int j = 0; j < 9; j++) row[j] = (i < NV) ? VEC[i][j] : 16'h0;
      run_frame((i % 2) == 0, row);
      if (i == 0) begin
        chk("R9 first frame silent s0", cap0, 32'd0);
        chk("R9 first frame silent s1", cap1, 32'd0);
        chk("R9 no early strobe", 32'(got_valid), 32'd0);
      end else begin
        for (int j = 0; j < 9; j++) row[j] = VEC[i-1][j];
        check_prev(row);
      end
    end

    // R8: a partial frame, then a sync at an unexpected position
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      sync = 1'b0;
      sdin = 2'b11;
    end
    foreach (junk[j]) junk[j] = 16'h0000;
    junk[0] = 16'h9C3A; junk[1] = 16'h0F81; junk[2] = 16'h7E01; junk[3] = 16'hC0DE;
    junk[4] = 16'hA000; junk[5] = 16'h0FFF; junk[6] = 16'h8421; junk[7] = 16'h1248;
    junk[8] = 16'h0040;
    run_frame(1'b1, junk);
    chk("R8 no strobe on cut frame", 32'(got_valid), 32'd0);
    chk("R8 no mid strobe", 32'(got_mid), 32'd0);
    run_frame(1'b0, zero);
    chk("R8 realigned s0 left", 32'(got_rx[0]), 32'h9C3A);
    chk("R8 realigned s0 right", 32'(got_rx[1]), 32'h0F81);
    chk("R8 realigned s1 left", 32'(got_rx[2]), 32'h7E01);
    chk("R8 realigned s1 right", 32'(got_rx[3]), 32'hC0DE);
    check_prev(junk);

    // R11: reset mid-frame clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset again sdout", 32'(sdout), 32'd0);
    chk("R11 reset again rx", rxl | rxr, 32'd0);
    done = 1;
    finish_run();
  end
endmodule